// File: doc/BRIEF.md
# Armed Compare Alarm Channel

This block is one alarm channel of a low-power timekeeping unit. A free-running 32-bit time slice, one count per 8 us, arrives from outside together with a strobe that marks the cycles on which the slice has moved. Software programs a 32-bit target through a write strobe. That write also arms the channel. While the channel is armed, it tests the time against the target and raises a single event.

The test tolerates lateness. The channel fires when the time equals the target, or when the time has passed the target by no more than one second (125000 counts). The difference is taken modulo 2^32, so the test stays correct across counter wrap. A target written up to one second in the past therefore fires at once. After it fires, the channel falls back to unarmed.

The block also keeps a raw interrupt status bit. Software has set and clear strobes for that bit. Software can also disarm the channel. A disarm that lands in the same cycle as a match does not stop the event.

Top module: `cmp_alarm_top`

## Requirements
- R1: After reset, `armed`, `event_pulse` and `raw_status` are all 0.
- R2: A cycle with `cmp_wr`=1 loads `cmp_wdata` as the target. After that clock edge, `armed` is 1 and `raw_status` is 0, unless `ev_set` is also high.
- R3: A match occurs in a cycle when all of the following hold:
  - the channel is armed;
  - either `time_tick`=1, or it is the first cycle after a target write;
  - (`time_val` − target) mod 2^32 ≤ 125000.
  On a match without `cmp_wr`, after that edge `event_pulse` is 1 for one cycle, `raw_status` is 1 and `armed` is 0.
- R4: When (`time_val` − target) mod 2^32 > 125000, no event occurs and the channel stays armed. This covers a target in the future and a target more than 125000 counts in the past.
- R5: After the channel fires, no further event comes from the compare until the next target write.
- R6: `arm_req` has no effect; an unarmed channel stays unarmed.
- R7: `disarm_req` without a match and without a write clears `armed` after the edge. It gives no event and leaves `raw_status` unchanged.
- R8: `disarm_req` in the same cycle as a match still produces the event and sets `raw_status`.
- R9: `ev_clr`=1 clears `raw_status` after the edge. A set from `ev_set` or from a match in the same cycle wins over the clear.
- R10: `ev_set`=1 gives a one-cycle `event_pulse` and sets `raw_status` after the edge. It does not change `armed`.
- R11: While `time_tick`=0, except in the first cycle after a write, a change of `time_val` into the window produces no event.
- R12: A target write in the same cycle as a match takes precedence. No event results, and the channel is armed with the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_val | input | 32 | Current time slice, 8 us per count |
| time_tick | input | 1 | High in cycles where `time_val` has a new value |
| cmp_wr | input | 1 | Target write strobe; arms the channel |
| cmp_wdata | input | 32 | Target value written with `cmp_wr` |
| arm_req | input | 1 | Set-arm request; ignored by this compare channel |
| disarm_req | input | 1 | Disarm request |
| ev_set | input | 1 | Diagnostic strobe forcing event and status |
| ev_clr | input | 1 | Clear strobe for the raw status bit |
| armed | output | 1 | 1 while the channel is armed |
| event_pulse | output | 1 | One-cycle event pulse |
| raw_status | output | 1 | Raw interrupt status bit |

## Verification
Every output is registered, so a strobe or a match seen in cycle k shows at the ports after the edge that closes cycle k. A target that is already inside the window fires one edge later than a tick would, because it is evaluated in the first cycle after the write. The bench drives each cycle's inputs at the falling edge and predicts the next state of `armed`, `raw_status` and `event_pulse` from the requirements. It samples all three at the following falling edge, one full edge after the stimulus. Directed cases cover the window edges 125000 and 125001, counter wrap, and same-cycle collisions of disarm, write, set and clear. A seeded random run follows them.

// File: rtl/cmp_alarm_pkg.sv
package cmp_alarm_pkg;

  localparam int unsigned TIME_W_DEF = 32;
  localparam int unsigned LATE_WIN_DEF = 125000;

  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_RAISE = 2'd1,
    FLAG_DROP = 2'd2
  } flag_op_e;

endpackage

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int unsigned TW = 32,
  parameter int unsigned LATE_WIN = 125000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_val,
  input  logic          time_tick,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          armed_q,
  input  logic          first_eval,
  output logic          hit
);

  localparam logic [TW-1:0] WIN_W = TW'(LATE_WIN);

  logic [TW-1:0] target_q;
  logic [TW-1:0] lateness;
  logic          eval_now;

  always_ff @(posedge clk) begin
    if (rst) target_q <= '0;
    else if (cmp_wr) target_q <= cmp_wdata;
  end

  always_comb begin
    lateness = time_val - target_q;
    eval_now = time_tick | first_eval;
    hit = armed_q & eval_now & (lateness <= WIN_W);
  end

  // R4
  far_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (time_val - target_q > WIN_W) |-> !hit);

  // R11
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!time_tick && !first_eval) |-> !hit);

endmodule

// File: rtl/cmp_arm_ctrl.sv
module cmp_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cmp_wr,
  input  logic arm_req,
  input  logic disarm_req,
  input  logic hit,
  output logic armed_q,
  output logic first_eval,
  output logic fire
);

  logic unused_arm_req;
  assign unused_arm_req = arm_req;

  assign fire = hit & ~cmp_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      first_eval <= 1'b0;
    end else begin
      first_eval <= cmp_wr;
      if (cmp_wr) armed_q <= 1'b1;
      else if (fire || disarm_req) armed_q <= 1'b0;
    end
  end

  // R2
  wr_arms_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> armed_q);

  // R6
  arm_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_req && !cmp_wr && !armed_q) |=> !armed_q);

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (disarm_req && !cmp_wr) |=> !armed_q);

  // R5
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(cmp_wr));

endmodule

// File: rtl/cmp_flag.sv
module cmp_flag
  import cmp_alarm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ev_set,
  input  logic ev_clr,
  input  logic cmp_wr,
  output logic event_q,
  output logic status_q
);

  flag_op_e op;

  always_comb begin
    if (fire || ev_set) op = FLAG_RAISE;
    else if (ev_clr || cmp_wr) op = FLAG_DROP;
    else op = FLAG_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      event_q <= 1'b0;
      status_q <= 1'b0;
    end else begin
      event_q <= fire | ev_set;
      case (op)
        FLAG_RAISE: status_q <= 1'b1;
        FLAG_DROP: status_q <= 1'b0;
        default: status_q <= status_q;
      endcase
    end
  end

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && !ev_set && !ev_clr && !cmp_wr) |=> $stable(status_q));

  // R10
  set_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ev_set |=> (event_q && status_q));

endmodule

// File: rtl/cmp_alarm_top.sv
module cmp_alarm_top #(
  parameter int unsigned TW = cmp_alarm_pkg::TIME_W_DEF,
  parameter int unsigned LATE_WIN = cmp_alarm_pkg::LATE_WIN_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_val,
  input  logic          time_tick,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          arm_req,
  input  logic          disarm_req,
  input  logic          ev_set,
  input  logic          ev_clr,
  output logic          armed,
  output logic          event_pulse,
  output logic          raw_status
);

  logic armed_q;
  logic first_eval;
  logic hit;
  logic fire;

  cmp_match #(.TW(TW), .LATE_WIN(LATE_WIN)) match_i (
    .clk(clk), .rst(rst), .time_val(time_val), .time_tick(time_tick),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .armed_q(armed_q),
    .first_eval(first_eval), .hit(hit)
  );

  cmp_arm_ctrl arm_i (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .arm_req(arm_req),
    .disarm_req(disarm_req), .hit(hit), .armed_q(armed_q),
    .first_eval(first_eval), .fire(fire)
  );

  cmp_flag flag_i (
    .clk(clk), .rst(rst), .fire(fire), .ev_set(ev_set), .ev_clr(ev_clr),
    .cmp_wr(cmp_wr), .event_q(event_pulse), .status_q(raw_status)
  );

  assign armed = armed_q;

  // R3
  event_source_chk: assert property (@(posedge clk) disable iff (rst)
    (event_pulse && !$past(ev_set)) |-> ($past(armed_q) && !armed_q));

  // R8
  disarm_loses_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && disarm_req && !cmp_wr) |=> (event_pulse && raw_status));

  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && cmp_wr && !ev_set) |=> (!event_pulse && armed_q));

endmodule

// File: tb/cmp_alarm_top_tb_top.sv
`timescale 1ns/1ps
module cmp_alarm_top_tb_top;

  localparam int unsigned WIN = 125000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] time_val = '0;
  logic time_tick = 1'b0;
  logic cmp_wr = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic arm_req = 1'b0;
  logic disarm_req = 1'b0;
  logic ev_set = 1'b0;
  logic ev_clr = 1'b0;
  logic armed, event_pulse, raw_status;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic m_armed = 0, m_pend = 0, m_status = 0, m_event = 0;
  logic [31:0] m_cmp = '0;
  logic [31:0] cur_tv = '0;

  always #2.5 clk = ~clk;

  cmp_alarm_top dut_i (
    .clk(clk), .rst(rst), .time_val(time_val), .time_tick(time_tick),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .arm_req(arm_req),
    .disarm_req(disarm_req), .ev_set(ev_set), .ev_clr(ev_clr),
    .armed(armed), .event_pulse(event_pulse), .raw_status(raw_status)
  );

  function automatic logic in_win(input logic [31:0] t, input logic [31:0] c);
    logic [31:0] d;
    d = t - c;
    return d <= WIN;
  endfunction

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic tk, input logic [31:0] tv, input logic wr,
                      input logic [31:0] wd, input logic dis, input logic arm,
                      input logic st, input logic cl, input string tag);
    logic hit, fire;
    time_tick = tk; time_val = tv; cmp_wr = wr; cmp_wdata = wd;
    disarm_req = dis; arm_req = arm; ev_set = st; ev_clr = cl;
    hit = m_armed && (tk || m_pend) && in_win(tv, m_cmp);
    fire = hit && !wr;
    m_event = fire || st;
    if (fire || st) m_status = 1'b1;
    else if (cl || wr) m_status = 1'b0;
    if (wr) m_armed = 1'b1;
    else if (fire || dis) m_armed = 1'b0;
    m_pend = wr;
    if (wr) m_cmp = wd;
    @(posedge clk);
    @(negedge clk);
    check(armed, m_armed, "armed", tag);
    check(event_pulse, m_event, "event_pulse", tag);
    check(raw_status, m_status, "raw_status", tag);
  endtask

  task automatic tick(input logic [31:0] tv, input string tag);
    cur_tv = tv;
    step(1, tv, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(armed, 0, "armed", "R1");
    check(event_pulse, 0, "event_pulse", "R1");
    check(raw_status, 0, "raw_status", "R1");

    // R2 write arms; target 10 in the future -> no fire (R4)
    step(0, 990, 1, 1000, 0, 0, 0, 0, "R2");
    step(0, 990, 0, 0, 0, 0, 0, 0, "R4");
    for (int i = 991; i < 1000; i++) tick(i, "R4");
    tick(1000, "R3");
    tick(1001, "R5");
    tick(1002, "R5");
    step(0, 1002, 0, 0, 0, 0, 0, 1, "R9");

    // R3 window edge: exactly 125000 in the past fires on first evaluation
    step(0, 200000, 1, 200000 - WIN, 0, 0, 0, 0, "R2");
    step(0, 200000, 0, 0, 0, 0, 0, 0, "R3");
    // R4 one count beyond the window: stays armed
    step(0, 200000, 1, 200000 - WIN - 1, 0, 0, 0, 0, "R2");
    step(0, 200000, 0, 0, 0, 0, 0, 0, "R4");
    tick(200001, "R4");

    // R7 disarm without match
    step(0, 200001, 0, 0, 1, 0, 0, 0, "R7");
    // R6 arm request ignored
    step(0, 200001, 0, 0, 0, 1, 0, 0, "R6");
    tick(200002, "R6");

    // R8 disarm in same cycle as match
    step(0, 200002, 1, 200005, 0, 0, 0, 0, "R2");
    tick(200003, "R8");
    tick(200004, "R8");
    step(1, 200005, 0, 0, 1, 0, 0, 0, "R8");

    // R10 set while armed keeps armed; R9 set wins over clear
    step(0, 200005, 1, 300000, 0, 0, 0, 0, "R2");
    step(0, 200005, 0, 0, 0, 0, 1, 0, "R10");
    step(0, 200005, 0, 0, 0, 0, 1, 1, "R9");
    step(0, 200005, 0, 0, 0, 0, 0, 1, "R9");

    // R11 time moves into window without tick -> no event
    step(0, 300000, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 300001, 0, 0, 0, 0, 0, 0, "R11");
    tick(300002, "R3");

    // R12 write in a matching cycle wins
    step(0, 300002, 1, 300010, 0, 0, 0, 0, "R2");
    step(0, 300002, 0, 0, 0, 0, 0, 0, "R12");
    step(1, 300010, 1, 400000, 0, 0, 0, 0, "R12");
    tick(300011, "R12");

    // R3 wrap: target near top, time past zero
    step(0, 32'hFFFF_FFE0, 1, 32'hFFFF_FFF0, 0, 0, 0, 0, "R2");
    tick(32'hFFFF_FFE8, "R4");
    tick(32'h0000_0005, "R3");

    // random phase
    cur_tv = 32'd5000;
    for (int n = 0; n < 4000; n++) begin
      logic tk, wr, dis, arm, st, cl;
      logic [31:0] wd;
      tk = ($urandom_range(0, 1) == 0);
      if (tk) cur_tv = cur_tv + (($urandom_range(0, 15) == 0) ? $urandom_range(1, 200000) : 1);
      wr = ($urandom_range(0, 19) == 0);
      case ($urandom_range(0, 3))
        0: wd = cur_tv + $urandom_range(0, 40);
        1: wd = cur_tv - $urandom_range(0, 40);
        2: wd = cur_tv - WIN - 20 + $urandom_range(0, 40);
        default: wd = $urandom;
      endcase
      dis = ($urandom_range(0, 29) == 0);
      arm = ($urandom_range(0, 9) == 0);
      st = ($urandom_range(0, 39) == 0);
      cl = ($urandom_range(0, 19) == 0);
      step(tk, cur_tv, wr, wd, dis, arm, st, cl, "R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule